// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the combinational control that keeps a five-stage in-order integer pipeline correct when an instruction needs a register that an older instruction has not yet written back. The five stages are fetch, decode, execute, memory and writeback. Each cycle the block receives the register numbers and control flags held in the pipeline registers. It returns mux selects for the two execute-stage ALU operands and for the memory-stage store-data input. It also returns three stall controls: hold the program counter, hold the fetch/decode register, and turn the decode/execute entry into a bubble.

A mode input turns forwarding on or off. With forwarding off, a dependent instruction waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second half, so a decode in the same cycle as the write sees the new value. With forwarding on, results are taken from the execute/memory or memory/writeback register. A load followed by an ALU user of its result still costs one bubble. A load followed by a store of the loaded value needs no stall, because the value is forwarded from memory/writeback straight into the data-memory write input.

Top module: `hazard_fwd_ctl`

## Requirements
- R1: With forwarding on, an execute-stage source that matches the destination of a writing instruction in the execute/memory register gets select 2'b10.
- R2: With forwarding on, an execute-stage source that matches only the destination of a writing instruction in the memory/writeback register gets select 2'b01; with no match the select is 2'b00 (register file).
- R3: When both the execute/memory and the memory/writeback destinations match a source, the select is 2'b10.
- R4: The first operand select follows only the first source register and the second operand select follows only the second.
- R5: Register 0 never produces a forward select other than 2'b00 and never causes a stall.
- R6: With forwarding on, a load in execute whose destination is a used decode source raises pc_hold, ifid_hold and idex_bubble together. The exception is a store's data source.
- R7: With forwarding on, a store in decode whose data register is the destination of a load in execute does not stall. When that store is in memory and the load is in writeback, the store-data select is 1.
- R8: With forwarding on, a non-load ALU producer in execute never stalls a dependent instruction in decode, including when the dependent instruction uses it as a load base.
- R9: With forwarding off, all forward selects are 0. A used decode source that matches a writing destination in execute or in memory stalls the pipeline, store data included.
- R10: A match against the writeback-stage destination alone never stalls, in either mode.
- R11: A decode source field whose use flag is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | 1 = full forwarding, 0 = stall until writeback |
| id_rs1 | input | RW | Decode-stage first source register |
| id_rs2 | input | RW | Decode-stage second source register |
| id_use1 | input | 1 | Decode instruction reads its first source |
| id_use2 | input | 1 | Decode instruction reads its second source |
| id_store | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rs1 | input | RW | Execute-stage first source register |
| ex_rs2 | input | RW | Execute-stage second source register |
| ex_rd | input | RW | Execute-stage destination register |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RW | Memory-stage destination register |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_rs2 | input | RW | Memory-stage store-data register |
| mem_memwrite | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | RW | Writeback-stage destination register |
| wb_regwrite | input | 1 | Writeback-stage instruction writes a register |
| fwd_a | output | 2 | First ALU operand select (00 file, 10 ex/mem, 01 mem/wb) |
| fwd_b | output | 2 | Second ALU operand select (same encoding) |
| fwd_sd | output | 1 | Store-data select: 1 takes the memory/writeback value |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Insert a bubble into the decode/execute register |

## Verification
Store-data forwarding and the load-use stall can be active in the same cycle. This happens when a store sits in memory with its loaded data in writeback, while a younger load in execute feeds an ALU source in decode. The bench drives exactly that state and expects fwd_sd and all three stall controls high at once. A second overlap pairs an operand forward with a stall in no-forward mode, where the stall must assert while every select stays at the register file.

// File: rtl/hazard_fwd_ctl.sv
module hazard_fwd_ctl #(
  parameter int RW = 5
) (
  input  logic          fwd_en,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_store,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_regwrite,
  input  logic          ex_memread,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_regwrite,
  input  logic [RW-1:0] mem_rs2,
  input  logic          mem_memwrite,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_regwrite,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          fwd_sd,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble
);
  localparam logic [RW-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b10;
  localparam logic [1:0] SEL_MWB = 2'b01;

  logic ex_live, mem_live, wb_live;
  assign ex_live  = ex_regwrite  && (ex_rd  != ZERO_REG);
  assign mem_live = mem_regwrite && (mem_rd != ZERO_REG);
  assign wb_live  = wb_regwrite  && (wb_rd  != ZERO_REG);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic m_ok, input logic [RW-1:0] m_rd,
                                      input logic w_ok, input logic [RW-1:0] w_rd);
    if (m_ok && m_rd == src)      return SEL_EXM;
    else if (w_ok && w_rd == src) return SEL_MWB;
    else                          return SEL_RF;
  endfunction

  assign fwd_a  = fwd_en ? pick(ex_rs1, mem_live, mem_rd, wb_live, wb_rd) : SEL_RF;
  assign fwd_b  = fwd_en ? pick(ex_rs2, mem_live, mem_rd, wb_live, wb_rd) : SEL_RF;
  assign fwd_sd = fwd_en && mem_memwrite && wb_live && (wb_rd == mem_rs2);

  logic s1_ex, s2_ex, s1_mem, s2_mem, stall_off, stall_load, stall;
  assign s1_ex  = id_use1 && ex_live  && (ex_rd  == id_rs1);
  assign s2_ex  = id_use2 && ex_live  && (ex_rd  == id_rs2);
  assign s1_mem = id_use1 && mem_live && (mem_rd == id_rs1);
  assign s2_mem = id_use2 && mem_live && (mem_rd == id_rs2);

  assign stall_off  = !fwd_en && (s1_ex || s2_ex || s1_mem || s2_mem);
  assign stall_load = fwd_en && ex_memread && (s1_ex || (s2_ex && !id_store));
  assign stall      = stall_off || stall_load;

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  always_comb begin
    a_r9_off_no_fwd: assert (fwd_en || (fwd_a == SEL_RF && fwd_b == SEL_RF && !fwd_sd))
      else $error("forward select active with forwarding off");
    a_r5_zero_src_a: assert (ex_rs1 != ZERO_REG || fwd_a == SEL_RF)
      else $error("register 0 forwarded on operand A");
    a_r5_zero_src_b: assert (ex_rs2 != ZERO_REG || fwd_b == SEL_RF)
      else $error("register 0 forwarded on operand B");
    a_r10_wb_only_no_stall: assert (ex_regwrite || mem_regwrite || !pc_hold)
      else $error("stall with only a writeback producer");
    a_r8_alu_no_stall: assert (!fwd_en || ex_memread || !idex_bubble)
      else $error("stall on ALU producer with forwarding on");
    a_r11_unused_no_stall: assert (id_use1 || id_use2 || !ifid_hold)
      else $error("stall with no decode source in use");
    a_r3_sel_legal: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
      else $error("illegal forward select");
  end
endmodule

// File: tb/hazard_fwd_ctl_tb_top.sv
module hazard_fwd_ctl_tb_top;
  logic clk = 0;
  always #10 clk = ~clk;

  logic fwd_en, id_use1, id_use2, id_store, ex_regwrite, ex_memread;
  logic mem_regwrite, mem_memwrite, wb_regwrite;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_sd, pc_hold, ifid_hold, idex_bubble;

  hazard_fwd_ctl #(.RW(5)) dut_i (.*);

  typedef struct packed {
    logic en; logic [4:0] i1, i2; logic u1, u2, st;
    logic [4:0] e1, e2, ed; logic erw, emr;
    logic [4:0] md; logic mrw; logic [4:0] ms2; logic mmw;
    logic [4:0] wd; logic wrw;
    logic [1:0] xa, xb; logic xsd, xst; logic [3:0] rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    //  en i1 i2 u1 u2 st  e1 e2 ed erw emr md mrw ms2 mmw wd wrw xa xb sd st rq
    '{1, 0, 0, 0, 0, 0,  2, 0, 0, 0, 0,  2, 1, 0, 0,  0, 0,  2, 0, 0, 0, 1},  // R1
    '{1, 0, 0, 0, 0, 0,  0, 5, 0, 0, 0,  0, 0, 0, 0,  5, 1,  0, 1, 0, 0, 2},  // R2
    '{1, 0, 0, 0, 0, 0,  7, 0, 0, 0, 0,  7, 1, 0, 0,  7, 1,  2, 0, 0, 0, 3},  // R3
    '{1, 0, 0, 0, 0, 0,  3, 4, 0, 0, 0,  4, 1, 0, 0,  9, 1,  0, 2, 0, 0, 4},  // R4
    '{1, 0, 0, 1, 1, 0,  0, 0, 0, 1, 1,  0, 1, 0, 1,  0, 1,  0, 0, 0, 0, 5},  // R5
    '{1, 7, 0, 1, 0, 0,  0, 0, 7, 1, 1,  0, 0, 0, 0,  0, 0,  0, 0, 0, 1, 6},  // R6
    '{1, 0, 9, 0, 1, 0,  0, 0, 9, 1, 1,  0, 0, 0, 0,  0, 0,  0, 0, 0, 1, 6},  // R6
    '{1, 8, 7, 1, 1, 1,  0, 0, 7, 1, 1,  0, 0, 0, 0,  0, 0,  0, 0, 0, 0, 7},  // R7
    '{1, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0,  0, 0, 7, 1,  7, 1,  0, 0, 1, 0, 7},  // R7
    '{1,11, 0, 1, 0, 0, 11, 0,11, 1, 0, 11, 1, 0, 0,  0, 0,  2, 0, 0, 0, 8},  // R8
    '{0, 2, 0, 1, 0, 0,  2, 0, 2, 1, 0,  2, 1, 0, 0,  0, 0,  0, 0, 0, 1, 9},  // R9
    '{0, 0, 5, 0, 1, 0,  0, 0, 0, 0, 0,  5, 1, 0, 0,  0, 0,  0, 0, 0, 1, 9},  // R9
    '{0, 0, 7, 0, 1, 1,  0, 0, 7, 1, 1,  0, 0, 7, 1,  7, 1,  0, 0, 0, 1, 9},  // R9
    '{0, 4, 0, 1, 0, 0,  0, 0, 0, 0, 0,  0, 0, 0, 0,  4, 1,  0, 0, 0, 0,10},  // R10
    '{1, 0, 6, 0, 0, 0,  0, 0, 6, 1, 1,  0, 0, 0, 0,  0, 0,  0, 0, 0, 0,11},  // R11
    '{1, 3, 7, 1, 0, 0,  0, 0, 3, 1, 1,  0, 0, 7, 1,  7, 1,  0, 0, 1, 1, 7}   // R7 with R6 stall
  };

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    fwd_en = v.en; id_rs1 = v.i1; id_rs2 = v.i2; id_use1 = v.u1; id_use2 = v.u2;
    id_store = v.st; ex_rs1 = v.e1; ex_rs2 = v.e2; ex_rd = v.ed;
    ex_regwrite = v.erw; ex_memread = v.emr; mem_rd = v.md; mem_regwrite = v.mrw;
    mem_rs2 = v.ms2; mem_memwrite = v.mmw; wb_rd = v.wd; wb_regwrite = v.wrw;
    #5;
  endtask

  task automatic check_out(input string req, input vec_t v);
    chk(req, "fwd_a", fwd_a, v.xa);
    chk(req, "fwd_b", fwd_b, v.xb);
    chk(req, "fwd_sd", fwd_sd, v.xsd);
    chk(req, "pc_hold", pc_hold, v.xst);
    chk(req, "ifid_hold", ifid_hold, v.xst);
    chk(req, "idex_bubble", idex_bubble, v.xst);
  endtask

  initial begin
    vec_t v;
    v = '0;
    apply(v);
    check_out("R2 idle", v);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check_out($sformatf("R%0d row%0d", TBL[i].rq, i), TBL[i]);
    end

    // R3 priority on operand B
    v = '0; v.en = 1; v.e2 = 12; v.md = 12; v.mrw = 1; v.wd = 12; v.wrw = 1; v.xb = 2;
    apply(v); check_out("R3 opB", v);

    // R5 register 0 match in no-forward mode, no stall
    v = '0; v.u1 = 1; v.u2 = 1; v.erw = 1; v.mrw = 1;
    apply(v); check_out("R5 off", v);

    // R9 same dependence with forwarding on only forwards, off stalls
    v = '0; v.en = 1; v.i1 = 6; v.u1 = 1; v.md = 6; v.mrw = 1; v.e1 = 6; v.xa = 2;
    apply(v); check_out("R9 on", v);
    v.en = 0; v.xa = 0; v.xst = 1;
    apply(v); check_out("R9 off", v);

    // R6 load result to store base still stalls
    v = '0; v.en = 1; v.st = 1; v.i1 = 14; v.u1 = 1; v.i2 = 15; v.u2 = 1;
    v.ed = 14; v.erw = 1; v.emr = 1; v.xst = 1;
    apply(v); check_out("R6 store base", v);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule